// File: doc/BRIEF.md
# Color-Sequenced Odd/Even Offset Corrector

This block sits right after the converter of a three-color scanner front end. Each digitized pixel arrives as an unsigned 12-bit sample. The block adds a signed 8-bit correction to it. The correction is picked from six stored values: one even and one odd value for each of red, green and blue. The block applies this correction before any pixel-rate offset or gain stage further down the path.

An internal channel counter steps through red, green and blue on every accepted pixel. A parity flag toggles after each complete blue pixel. A line-run input is sampled on every clock edge. While it is low, the block holds the sequence at the start of a line: red, in an even set.

Software loads the six corrections through a small write port. It first writes a color pointer, then writes an even or an odd value. Each corrected sample leaves through one register stage, together with its color tag and its parity flag.

Top module: `colseq_offset_corr`

## Requirements
- R1: After reset, all six correction values are zero, the sequence is at red/even, and `out_valid` is low.
- R2: A write with `reg_addr` = 0 loads the color pointer from `reg_wdata[1:0]` (0 red, 1 green, 2 blue). A write with `reg_addr` = 1 loads the even value, and one with `reg_addr` = 2 loads the odd value, of the color the pointer holds at that cycle. If the pointer holds 3, or if `reg_addr` is 3, the write changes no correction value.
- R3: A clock edge with `line_run` low returns the sequence to red/even. A pixel offered in that cycle produces no output.
- R4: Accepted pixels are tagged in the repeating order red, green, blue. On `out_color` the codes are 0 for red, 1 for green and 2 for blue. The first pixel after a restart is red.
- R5: The first red/green/blue set after a restart is even (`out_odd` = 0), and the parity alternates after each complete set.
- R6: The correction is an 8-bit two's-complement value in LSB steps (0x7F is +127, 0xFF is -1, 0x80 is -128). It is added to the sample of the matching color and parity.
- R7: The corrected result saturates to the range 0 to 4095.
- R8: An accepted pixel (`pix_valid` and `line_run` both high) appears on the outputs one clock later, with its color and parity aligned to the data and `out_valid` high. In every other case `out_valid` is low one clock later.
- R9: A register write in the same cycle as an accepted pixel does not affect that pixel. It takes effect from the next pixel on.
- R10: A cycle with `pix_valid` low and `line_run` high leaves the color and parity sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 pointer, 1 even value, 2 odd value, 3 none |
| reg_wdata | input | 8 | Write data |
| line_run | input | 1 | Low restarts the line at red/even |
| pix_valid | input | 1 | Sample present on `pix_data` |
| pix_data | input | 12 | Unsigned converter sample |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 12 | Corrected, saturated sample |
| out_color | output | 2 | Color tag of `out_data` |
| out_odd | output | 1 | Parity flag of `out_data` |

## Verification
Because each output carries its own color tag and parity flag, a slip in the channel counter or in the parity toggle shows at the ports on the very next pixel after the fault. A register decoded to the wrong color or parity shows as a wrong sum on the first pixel that reads it. The sweep therefore loads distinct even and odd values for every color, so that any mix-up changes `out_data`. Saturation errors only show for samples near 0 or 4095, so those samples are driven under every correction value.

// File: rtl/oe_pkg.sv
package oe_pkg;

    localparam int unsigned NUM_CHAN = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2,
        CH_NONE  = 2'd3
    } chan_e;

    typedef enum logic [1:0] {
        RA_PTR  = 2'd0,
        RA_EVEN = 2'd1,
        RA_ODD  = 2'd2,
        RA_NONE = 2'd3
    } raddr_e;

    typedef struct packed {
        chan_e chan;
        logic  odd;
    } seq_state_t;

endpackage

// File: rtl/oe_chan_seq.sv
module oe_chan_seq
    import oe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_run,
    input  logic  pix_take,
    output chan_e chan,
    output logic  odd
);

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!line_run) begin
            seq_d.chan = CH_RED;
            seq_d.odd  = 1'b0;
        end else if (pix_take) begin
            if (seq_q.chan == CH_BLUE) begin
                seq_d.chan = CH_RED;
                seq_d.odd  = ~seq_q.odd;
            end else begin
                seq_d.chan = chan_e'(seq_q.chan + 2'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{chan: CH_RED, odd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign chan = seq_q.chan;
    assign odd  = seq_q.odd;

    // R3: a low line_run restarts the line
    a_r3_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !line_run |=> (chan == CH_RED && !odd));

    // R4: the channel counter never reaches the unused code
    a_r4_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
        chan != CH_NONE);

    // R5: parity flips after a blue pixel
    a_r5_set_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (line_run && pix_take && chan == CH_BLUE) |=> (odd != $past(odd)));

    // R10: idle cycles hold the sequence
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (line_run && !pix_take) |=> ($stable(chan) && $stable(odd)));

endmodule

// File: rtl/oe_ofs_bank.sv
module oe_ofs_bank
    import oe_pkg::*;
#(
    parameter int unsigned OFS_W = 8,
    parameter int unsigned NCHAN = NUM_CHAN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  raddr_e           wr_addr,
    input  logic [OFS_W-1:0] wr_data,
    input  chan_e            rd_chan,
    input  logic             rd_odd,
    output logic [OFS_W-1:0] rd_ofs
);

    localparam int unsigned NREG = 2 * NCHAN;

    typedef struct packed {
        chan_e                      ptr;
        logic [NREG-1:0][OFS_W-1:0] ofs;
    } bank_t;

    bank_t           bank_d, bank_q;
    logic [NREG-1:0] hit;

    // one write-enable decode per stored value: entry i is color i/2, parity i%2
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign hit[i] = wr_en
                     && (wr_addr == (((i % 2) == 1) ? RA_ODD : RA_EVEN))
                     && (bank_q.ptr == chan_e'(i / 2));
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en && wr_addr == RA_PTR) begin
            bank_d.ptr = chan_e'(wr_data[1:0]);
        end
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                bank_d.ofs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{ptr: CH_RED, ofs: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    // read uses the registered copy, so a write in the same cycle is seen one pixel later
    always_comb begin
        rd_ofs = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_chan == chan_e'(i / 2) && rd_odd == ((i % 2) == 1)) begin
                rd_ofs = bank_q.ofs[i];
            end
        end
    end

    // R2: at most one value written per cycle
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R2: writes with no target leave every value untouched
    a_r2_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != RA_PTR && (bank_q.ptr == CH_NONE || wr_addr == RA_NONE))
            |=> $stable(bank_q.ofs));

endmodule

// File: rtl/oe_sat_add.sv
module oe_sat_add #(
    parameter int unsigned SMP_W = 12,
    parameter int unsigned OFS_W = 8
) (
    input  logic [SMP_W-1:0] sample,
    input  logic [OFS_W-1:0] ofs,
    output logic [SMP_W-1:0] result
);

    localparam int unsigned SUM_W = SMP_W + 2;

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, sample}) + $signed({{(SUM_W - OFS_W){ofs[OFS_W-1]}}, ofs});
        if (sum[SUM_W-1]) begin
            result = '0;
        end else if (sum[SMP_W]) begin
            result = '1;
        end else begin
            result = sum[SMP_W-1:0];
        end
    end

endmodule

// File: rtl/colseq_offset_corr.sv
module colseq_offset_corr
    import oe_pkg::*;
#(
    parameter int unsigned SMP_W = 12,
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [OFS_W-1:0] reg_wdata,
    input  logic             line_run,
    input  logic             pix_valid,
    input  logic [SMP_W-1:0] pix_data,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    output logic [1:0]       out_color,
    output logic             out_odd
);

    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] data;
        chan_e            chan;
        logic             odd;
    } out_t;

    chan_e            cur_chan;
    logic             cur_odd;
    logic [OFS_W-1:0] cur_ofs;
    logic [SMP_W-1:0] fixed;
    logic             take;
    out_t             out_d, out_q;

    assign take = pix_valid && line_run;

    oe_chan_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_run (line_run),
        .pix_take (pix_valid),
        .chan     (cur_chan),
        .odd      (cur_odd)
    );

    oe_ofs_bank #(.OFS_W(OFS_W), .NCHAN(NUM_CHAN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (raddr_e'(reg_addr)),
        .wr_data (reg_wdata),
        .rd_chan (cur_chan),
        .rd_odd  (cur_odd),
        .rd_ofs  (cur_ofs)
    );

    oe_sat_add #(.SMP_W(SMP_W), .OFS_W(OFS_W)) u_add (
        .sample (pix_data),
        .ofs    (cur_ofs),
        .result (fixed)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = take;
        if (take) begin
            out_d.data = fixed;
            out_d.chan = cur_chan;
            out_d.odd  = cur_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, data: '0, chan: CH_RED, odd: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;
    assign out_color = out_q.chan;
    assign out_odd   = out_q.odd;

    // R8: one-cycle latency on the valid flag
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_run) |=> out_valid);

    // R3: pixels offered while the line is held produce nothing
    a_r3_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && line_run) |=> !out_valid);

    // R4: emitted tags follow the sequencer, one cycle later
    a_r4_tag_align: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_run) |=> (out_color == $past(cur_chan) && out_odd == $past(cur_odd)));

endmodule

// File: tb/colseq_offset_corr_test.sv
module colseq_offset_corr_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        line_run = 1'b0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_data = 12'd0;
    logic        out_valid;
    logic [11:0] out_data;
    logic [1:0]  out_color;
    logic        out_odd;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_ofs [6];
    int         m_ptr = 0;
    int         m_col = 0;
    int         m_odd = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    colseq_offset_corr uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .line_run  (line_run),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_color (out_color),
        .out_odd   (out_odd)
    );

    function automatic logic [11:0] sat_sum(input int s, input logic [7:0] o);
        int v;
        v = s + ((o > 8'd127) ? int'(o) - 256 : int'(o));
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return 12'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, check registered result at next negedge
    task automatic step(input bit wr, input logic [1:0] addr, input logic [7:0] wd,
                        input bit pv, input logic [11:0] pd, input bit run);
        bit          e_val;
        logic [11:0] e_dat;
        int          e_col, e_odd;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        pix_valid = pv; pix_data = pd; line_run = run;
        e_val = pv && run;
        e_dat = sat_sum(int'(pd), m_ofs[m_col * 2 + m_odd]);   // R9: old value
        e_col = m_col;
        e_odd = m_odd;
        if (wr) begin
            if (addr == 2'd0) m_ptr = int'(wd[1:0]);
            else if (addr != 2'd3 && m_ptr < 3) m_ofs[m_ptr * 2 + (addr == 2'd2 ? 1 : 0)] = wd;
        end
        if (!run) begin
            m_col = 0; m_odd = 0;
        end else if (pv) begin
            if (m_col == 2) begin m_col = 0; m_odd = 1 - m_odd; end
            else m_col++;
        end
        @(negedge clk);
        check("R8 out_valid", int'(out_valid), int'(e_val));
        if (e_val) begin
            check("R6/R7 out_data", int'(out_data), int'(e_dat));
            check("R4 out_color", int'(out_color), e_col);
            check("R5 out_odd", int'(out_odd), e_odd);
        end
    endtask

    task automatic wr_reg(input logic [1:0] addr, input logic [7:0] d);
        step(1'b1, addr, d, 1'b0, 12'd0, 1'b1);
    endtask

    task automatic pix(input logic [11:0] d);
        step(1'b0, 2'd0, 8'd0, 1'b1, d, 1'b1);
    endtask

    task automatic restart();
        step(1'b0, 2'd0, 8'd0, 1'b0, 12'd0, 1'b0);
    endtask

    task automatic load(input int col, input logic [7:0] ev, input logic [7:0] od);
        wr_reg(2'd0, 8'(col));
        wr_reg(2'd1, ev);
        wr_reg(2'd2, od);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_ofs[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid after reset", int'(out_valid), 0);
        for (int i = 0; i < 6; i++) pix(12'(i * 700 + 5));   // R1 zero values, R4/R5 order

        // R2 R6 R7: sweep every correction value on every color and parity
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 3; c++) load(c, 8'(v + c * 37), 8'((v + c * 37) ^ 8'h5A));
            restart();
            pix(12'd0); pix(12'd4095); pix(12'd2048);
            pix(12'(v * 16)); pix(12'd100); pix(12'd4000);
        end

        // distinct values, gaps in the pixel stream (R10), long line (R5)
        load(0, 8'h01, 8'hFF);
        load(1, 8'h7F, 8'h80);
        load(2, 8'h10, 8'hF0);
        restart();
        for (int k = 0; k < 18; k++) begin
            if (k % 4 == 3) step(1'b0, 2'd0, 8'd0, 1'b0, 12'd0, 1'b1);  // R10 idle
            pix(12'(1000 + k * 13));
        end

        // R2: pointer 3 and address 3 write nothing
        wr_reg(2'd0, 8'd3);
        wr_reg(2'd1, 8'h55);
        wr_reg(2'd2, 8'h66);
        wr_reg(2'd3, 8'h77);
        restart();
        for (int k = 0; k < 6; k++) pix(12'd2000);

        // R9: write in the same cycle as a pixel
        wr_reg(2'd0, 8'd0);
        restart();
        step(1'b1, 2'd1, 8'h40, 1'b1, 12'd500, 1'b1);   // red even, old value
        pix(12'd500); pix(12'd500);
        restart();
        pix(12'd500);                                   // red even, new value

        // R3: restart mid-line with a pixel offered
        pix(12'd300);
        step(1'b0, 2'd0, 8'd0, 1'b1, 12'd300, 1'b0);
        for (int k = 0; k < 4; k++) pix(12'd300);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule